// File: doc/BRIEF.md
# Serially programmed reference divider

This block divides its reference clock by an 11-bit ratio that is written over a three-wire serial port: a serial clock, a data line and a latch strobe. A 24-bit word is shifted in, most significant bit first. When the strobe rises, the block checks the word's select bit and test bits. A qualifying word sets a new divide ratio, and any other word is dropped.

The divider emits a pulse one reference clock wide once every N reference cycles. The pulse serves as the comparison frequency for a phase detector further along the chain. All three serial pins are oversampled in the reference clock domain through two-stage synchronisers, so the serial clock must be much slower than the reference. A newly loaded ratio waits until the current count period has ended, so no output period is ever cut short or stretched.

Top module: `serial_ref_divider`

## Requirements
- R1: Serial data is sampled on each rising edge of `ser_clk_i`, most significant bit first, into a 24-bit frame. Frame bit 0 is the first bit sent and frame bit 23 is the last. Each serial clock phase and the data setup must last at least four reference clock cycles.
- R2: A rising edge of `ser_le_i` loads a ratio only if two conditions hold: frame bit 23 (the select bit) is 0, and frame bits 8 and 9 are 1 and 0. Every other word leaves the divide ratio unchanged.
- R3: Frame bits 0 to 7, 21 and 22 have no effect on the loaded ratio.
- R4: Frame bits 10 to 20 hold the ratio as an unsigned number, with bit 10 as the MSB. A field of 192 gives an output period of 192 reference cycles, and a field of 2047 gives 2047.
- R5: A field value below 5 is loaded as 5.
- R6: `cmp_pulse_o` is high for exactly one reference cycle, and consecutive pulses are exactly N cycles apart.
- R7: A new ratio takes effect only after the pulse that ends the period in progress. Each period uses either the old ratio or the new one in full.
- R8: While `rst_ni` is low, `cmp_pulse_o` is low, the ratio is 5 and the count is zero. The first pulse comes 5 reference cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Latch strobe, active on the rising edge |
| cmp_pulse_o | output | 1 | Divided comparison pulse |

## Verification
The hardest situation to reach is a ratio change that lands in the middle of a count period. Checking it means proving that the period in progress finishes with the old ratio and that the very next period uses the new one. The stimulus reaches this by sending words while the divider runs freely, with no alignment to the pulses. Random ratios near the minimum put the strobe at many different count phases. Each load is then followed by a check that every interval equals either the old ratio or the new one, and after that by exact checks at the new ratio.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  localparam int FRAME_W   = 24;
  localparam int RATIO_W   = 11;
  localparam int MIN_RATIO = 5;
  // positions inside the shift register (last bit sent lands at index 0)
  localparam int SEL_POS   = 0;
  localparam int FLD_LSB   = 3;
  localparam int TEST_LO   = 14;
  localparam int TEST_HI   = 15;
  localparam logic [1:0] TEST_OK = 2'b10;
endpackage

// File: rtl/rdiv_serial_rx.sv
module rdiv_serial_rx
  import rdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               ser_le_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               latch_o
);
  logic [2:0] sclk_s, data_s, le_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      data_s <= '0;
      le_s   <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], ser_clk_i};
      data_s <= {data_s[1:0], ser_data_i};
      le_s   <= {le_s[1:0], ser_le_i};
    end
  end

  logic sclk_rise, le_rise;
  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign le_rise   = le_s[1] & ~le_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      latch_o <= 1'b0;
    end else begin
      if (sclk_rise) frame_o <= {frame_o[FRAME_W-2:0], data_s[1]};
      latch_o <= le_rise;
    end
  end

  assert_latch_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
  assert_shift_on_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise |=> $stable(frame_o));
endmodule

// File: rtl/rdiv_decode.sv
module rdiv_decode
  import rdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               latch_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic               frame_ok;
  logic [RATIO_W-1:0] field;
  logic [RATIO_W-1:0] clamped;

  assign frame_ok = (frame_i[SEL_POS] == 1'b0) && (frame_i[TEST_HI:TEST_LO] == TEST_OK);
  assign field    = frame_i[FLD_LSB +: RATIO_W];
  assign clamped  = (field < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : field;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ratio_o <= RATIO_W'(MIN_RATIO);
    else if (latch_i && frame_ok) ratio_o <= clamped;
  end

  assert_ignore_bad_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !frame_ok) |=> $stable(ratio_o));
  assert_pending_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_o >= RATIO_W'(MIN_RATIO));
endmodule

// File: rtl/rdiv_counter.sv
module rdiv_counter
  import rdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               pulse_o
);
  logic [RATIO_W-1:0] cnt_q, ratio_q;
  logic               term;

  assign term = (cnt_q == ratio_q - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(MIN_RATIO);
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= term;
      if (term) begin
        cnt_q   <= '0;
        ratio_q <= ratio_i;   // reload only on period boundary
      end else begin
        cnt_q   <= cnt_q + RATIO_W'(1);
      end
    end
  end

  assert_cnt_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  assert_pulse_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  assert_ratio_at_term_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |-> $stable(ratio_q));
  assert_active_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= RATIO_W'(MIN_RATIO));
endmodule

// File: rtl/serial_ref_divider.sv
module serial_ref_divider
  import rdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_clk_i,
  input  logic ser_data_i,
  input  logic ser_le_i,
  output logic cmp_pulse_o
);
  logic [FRAME_W-1:0] frame;
  logic               latch;
  logic [RATIO_W-1:0] ratio_pend;

  rdiv_serial_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ser_clk_i  (ser_clk_i),
    .ser_data_i (ser_data_i),
    .ser_le_i   (ser_le_i),
    .frame_o    (frame),
    .latch_o    (latch)
  );

  rdiv_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame),
    .latch_i (latch),
    .ratio_o (ratio_pend)
  );

  rdiv_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_pend),
    .pulse_o (cmp_pulse_o)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    !rst_ni |-> !cmp_pulse_o);
endmodule

// File: tb/tb_serial_ref_divider.sv
module tb_serial_ref_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic pulse;

  int n_vec = 0, n_bad = 0;
  int since = 0, last_iv = 0, wide = 0;
  logic prev_p = 1'b0;
  int active = 5;
  event ev_pulse;

  always #2.5 clk = ~clk;

  serial_ref_divider dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk),
    .ser_data_i(sdata), .ser_le_i(sle), .cmp_pulse_o(pulse)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      since++;
      if (pulse && prev_p) wide++;
      if (pulse) begin
        last_iv = since;
        since = 0;
        ->ev_pulse;
      end
      prev_p = pulse;
    end
  end

  function automatic logic [23:0] mk(logic [7:0] dc0, logic [1:0] tst,
                                     logic [10:0] fld, logic [1:0] dc1, logic sel);
    return {dc0, tst, fld, dc1, sel};
  endfunction

  function automatic int exp_ratio(logic [23:0] w, int cur);
    int f;
    if (w[0] != 1'b0 || w[15:14] != 2'b10) return cur;
    f = int'(w[13:3]);
    return (f < 5) ? 5 : f;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      sdata = w[i];
      sclk = 1'b0; #40;
      sclk = 1'b1; #40;
    end
    sclk = 1'b0; #40;
    sle = 1'b1; #40;
    sle = 1'b0; #40;
  endtask

  task automatic apply(logic [23:0] w, string req);
    int nxt, old;
    old = active;
    nxt = exp_ratio(w, active);
    send(w);
    @ev_pulse;
    chk(last_iv == old || last_iv == nxt, "R7", last_iv, nxt);
    @ev_pulse;
    chk(last_iv == nxt, req, last_iv, nxt);
    @ev_pulse;
    chk(last_iv == nxt, req, last_iv, nxt);
    active = nxt;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(pulse == 1'b0, "R8", int'(pulse), 0);
    @(negedge clk); #1; rst_n = 1'b1;
    @ev_pulse;
    chk(last_iv == 5, "R8", last_iv, 5);
    @ev_pulse;
    chk(last_iv == 5, "R6", last_iv, 5);

    apply(mk(8'h00, 2'b10, 11'd192, 2'b00, 1'b0), "R4");
    apply(mk(8'h00, 2'b10, 11'd3, 2'b00, 1'b0), "R5");
    apply(mk(8'h00, 2'b10, 11'd9, 2'b00, 1'b0), "R1");
    apply(mk(8'h00, 2'b10, 11'd0, 2'b00, 1'b0), "R5");
    apply(mk(8'h00, 2'b10, 11'd5, 2'b00, 1'b0), "R5");
    apply(mk(8'h00, 2'b10, 11'd30, 2'b00, 1'b1), "R2");
    apply(mk(8'h00, 2'b11, 11'd31, 2'b00, 1'b0), "R2");
    apply(mk(8'h00, 2'b01, 11'd32, 2'b00, 1'b0), "R2");
    apply(mk(8'h00, 2'b00, 11'd33, 2'b00, 1'b0), "R2");
    apply(mk(8'hFF, 2'b10, 11'd7, 2'b11, 1'b0), "R3");
    apply(mk(8'hA5, 2'b10, 11'd13, 2'b10, 1'b0), "R3");
    apply(mk(8'h00, 2'b10, 11'd2047, 2'b00, 1'b0), "R4");
    apply(mk(8'h00, 2'b10, 11'd6, 2'b00, 1'b0), "R7");

    for (int k = 0; k < 16; k++) begin
      logic [23:0] w;
      logic [1:0] t;
      t = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b10;
      w = mk(8'($urandom), t, 11'($urandom_range(0, 80)), 2'($urandom),
             ($urandom_range(0, 4) == 0));
      apply(w, "R7");
    end

    chk(wide == 0, "R6", wide, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule